// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Read Lookup

This block serves read requests from a processor against a small two-way set-associative cache. It keeps the tag, valid and data arrays internally as register arrays. Each set has one predictor bit that names the way to probe first. On an accepted request, only the predicted way's tag is compared, and the output data multiplexer is already steered to that way. A match returns the word one cycle later. A mismatch falls back to checking the other way over the following cycles. A line found in neither way is fetched through a single-word refill port and installed in the way that was not predicted.

The predictor learns from each outcome. A hit in the other way re-points the bit at that way. A refill points the bit at the freshly written way. Three counters report predicted hits, other-way hits and full misses.

Both streaming ports use valid/ready. A request moves on an edge where `req_valid` and `req_ready` are both high. A response stays held, with stable data, until `rsp_ready` is seen high. `req_ready` is high only when the controller is idle and no response is stuck waiting, so at most one request is in flight. A refill request is held with a stable address until `mem_req_ready`. A refill response is a single-cycle `mem_rsp_valid` pulse with no back-pressure.

Top module: `wpc_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, all three counters read 0, every line is invalid and every predictor bit selects way 0.
- R2: When the predicted way holds a valid matching tag, `rsp_valid` is high with that line's word in the first cycle after the accepting edge. `cnt_fast` rises by one and the predictor bit is left unchanged.
- R3: When only the other way matches, `rsp_valid` stays low for two cycles and goes high with the word in the third cycle after the accepting edge. `cnt_slow` rises by one and the set's predictor bit then names the way that hit.
- R4: When neither way matches, `mem_req_valid` rises in the second cycle after the accepting edge with `mem_req_addr` equal to the request address. It stays high with a stable address until accepted by `mem_req_ready`, and drops in the following cycle.
- R5: On a `mem_rsp_valid` pulse after the refill request is taken, the word is written into the way the predictor did not name. The predictor bit is set to that way. The word is returned on `rsp_valid` in the next cycle, and `cnt_miss` rises by one.
- R6: From the acceptance of a request that is not a predicted hit until its response appears, `req_ready` stays low.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and `req_ready` stays low. The response is cleared on the edge where `rsp_ready` is seen.
- R8: A `mem_rsp_valid` pulse arriving before the refill request has been taken is ignored: it neither completes the request nor changes the returned word.
- R9: A refill never overwrites the predicted way, so the line that was in the predicted way is still found afterwards as an other-way hit.
- R10: At most one of the three counters advances in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address; low IDX_W bits select the set |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Refill request present |
| mem_req_ready | input | 1 | Lower memory takes the refill request |
| mem_req_addr | output | ADDR_W | Word address to refill |
| mem_rsp_valid | input | 1 | Refill word present (one-cycle pulse) |
| mem_rsp_data | input | DATA_W | Refill word |
| cnt_fast | output | CNT_W | Count of predicted-way hits |
| cnt_slow | output | CNT_W | Count of other-way hits |
| cnt_miss | output | CNT_W | Count of refills |

## Verification
Two addresses that share a set are alternated so that each one is seen cold, then as a predicted hit, then as an other-way hit after the other address has displaced the prediction. This separates the one-cycle, three-cycle and refill timings and shows that the predictor flips and that refills spare the predicted way. A swept pattern over four sets and five tags mixes all three outcomes. In that sweep, held responses, refill-port stalls of varying length and early stray refill pulses are interleaved, which tells true back-pressure handling apart from timing that only works with an always-ready neighbour. The bench model decides each outcome from its own tag, valid and predictor tables and checks the ports in every cycle of each transaction.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALT,
    ST_ALT2,
    ST_MREQ,
    ST_MWAIT
  } wpc_state_e;
endpackage

// File: rtl/wpc_store.sv
module wpc_store #(
  parameter int SETS   = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [1:0][TAG_W-1:0]       rd_tag,
  output logic [1:0]                  rd_vld,
  output logic [1:0][DATA_W-1:0]      rd_data,
  input  logic                        wr_en,
  input  logic                        wr_way,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [DATA_W-1:0]           wr_data
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];
    logic [SETS-1:0]   vld_q;
    logic              sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_mem[wr_idx]  <= wr_tag;
        data_mem[wr_idx] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   vld_q <= '0;
      else if (sel) vld_q[wr_idx] <= 1'b1;
    end

    assign rd_tag[w]  = tag_mem[rd_idx];
    assign rd_data[w] = data_mem[rd_idx];
    assign rd_vld[w]  = vld_q[rd_idx];
  end
endmodule

// File: rtl/wpc_predictor.sv
module wpc_predictor #(
  parameter int SETS  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_way
);
  logic [SETS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     bits_q <= '0;
    else if (wr_en) bits_q[wr_idx] <= wr_way;
  end

  assign rd_way = bits_q[rd_idx];
endmodule

// File: rtl/wpc_counters.sv
module wpc_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       inc,
  output logic [CNT_W-1:0] cnt_fast,
  output logic [CNT_W-1:0] cnt_slow,
  output logic [CNT_W-1:0] cnt_miss
);
  logic [2:0][CNT_W-1:0] cnt_q;

  for (genvar i = 0; i < 3; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q[i] <= '0;
      else if (inc[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
    end
  end

  assign cnt_fast = cnt_q[0];
  assign cnt_slow = cnt_q[1];
  assign cnt_miss = cnt_q[2];

  // R10: outcome events are exclusive
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inc) <= 1);
endmodule

// File: rtl/wpc_lookup.sv
module wpc_lookup
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  cnt_fast,
  output logic [CNT_W-1:0]  cnt_slow,
  output logic [CNT_W-1:0]  cnt_miss
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  wpc_state_e state_q, state_d;
  logic [IDX_W-1:0] lat_idx;
  logic [TAG_W-1:0] lat_tag;
  logic             lat_pred;

  logic [IDX_W-1:0]         req_idx, rd_idx;
  logic [TAG_W-1:0]         req_tag;
  logic [1:0][TAG_W-1:0]    rd_tag;
  logic [1:0]               rd_vld;
  logic [1:0][DATA_W-1:0]   rd_data;
  logic                     pred_way, alt_way, probe_way;
  logic                     accept, fast_hit, alt_hit;
  logic                     ev_fast, ev_slow, ev_miss;
  logic                     load_rsp, pred_wr;
  logic [DATA_W-1:0]        rsp_next;

  assign req_idx   = req_addr[IDX_W-1:0];
  assign req_tag   = req_addr[ADDR_W-1:IDX_W];
  assign rd_idx    = (state_q == ST_IDLE) ? req_idx : lat_idx;
  assign alt_way   = ~lat_pred;
  // data multiplexer steered by the prediction before any tag result
  assign probe_way = (state_q == ST_IDLE) ? pred_way : alt_way;

  assign req_ready = (state_q == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  // first cycle: one tag comparison, predicted way only
  assign fast_hit  = rd_vld[pred_way] && (rd_tag[pred_way] == req_tag);
  assign alt_hit   = rd_vld[alt_way] && (rd_tag[alt_way] == lat_tag);

  assign ev_fast = accept && fast_hit;
  assign ev_slow = (state_q == ST_ALT2);
  assign ev_miss = (state_q == ST_MWAIT) && mem_rsp_valid;
  assign pred_wr = ev_slow || ev_miss;

  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {lat_tag, lat_idx};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept && !fast_hit) state_d = ST_ALT;
      ST_ALT:   state_d = alt_hit ? ST_ALT2 : ST_MREQ;
      ST_ALT2:  state_d = ST_IDLE;
      ST_MREQ:  if (mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lat_idx  <= '0;
      lat_tag  <= '0;
      lat_pred <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        lat_idx  <= req_idx;
        lat_tag  <= req_tag;
        lat_pred <= pred_way;
      end
    end
  end

  assign load_rsp = ev_fast || ev_slow || ev_miss;
  assign rsp_next = (state_q == ST_MWAIT) ? mem_rsp_data : rd_data[probe_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (load_rsp) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rsp_next;
      end
    end
  end

  wpc_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_tag  (rd_tag),
    .rd_vld  (rd_vld),
    .rd_data (rd_data),
    .wr_en   (ev_miss),
    .wr_way  (alt_way),
    .wr_idx  (lat_idx),
    .wr_tag  (lat_tag),
    .wr_data (mem_rsp_data)
  );

  wpc_predictor #(.SETS(SETS), .IDX_W(IDX_W)) u_pred (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (rd_idx),
    .rd_way (pred_way),
    .wr_en  (pred_wr),
    .wr_idx (lat_idx),
    .wr_way (alt_way)
  );

  wpc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      ({ev_miss, ev_slow, ev_fast}),
    .cnt_fast (cnt_fast),
    .cnt_slow (cnt_slow),
    .cnt_miss (cnt_miss)
  );

  // R2: predicted-way hit answers on the next cycle
  p_fast_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fast_hit) |=> rsp_valid);

  // R6: a non-fast request blocks further requests
  p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fast_hit) |=> (!req_ready && !rsp_valid));

  // R4: refill request held stable until taken
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7: held response keeps its data
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5: refill word returned the cycle after it arrives
  p_refill_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_MWAIT) && mem_rsp_valid) |=> (rsp_valid && rsp_data == $past(mem_rsp_data)));
endmodule

// File: tb/wpc_lookup_tb.sv
module wpc_lookup_tb;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SETS   = 8;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic [CNT_W-1:0]  cnt_fast, cnt_slow, cnt_miss;

  always #2.5 clk = ~clk;

  wpc_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cnt_fast(cnt_fast), .cnt_slow(cnt_slow), .cnt_miss(cnt_miss)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference tables: set index = addr[2:0], tag = addr[11:3]
  int mtag [2][SETS];
  bit mval [2][SETS];
  bit mpred [SETS];
  int m_fast = 0, m_slow = 0, m_miss = 0;

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {4'hD, a, 4'h5, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_counters(input string req);
    chk(cnt_fast == CNT_W'(m_fast), req, "cnt_fast", cnt_fast, m_fast);
    chk(cnt_slow == CNT_W'(m_slow), req, "cnt_slow", cnt_slow, m_slow);
    chk(cnt_miss == CNT_W'(m_miss), req, "cnt_miss", cnt_miss, m_miss);
  endtask

  // kind: 0 predicted hit, 1 other-way hit, 2 miss
  task automatic read_op(input logic [ADDR_W-1:0] a, input int mdly,
                         input int hold, input bit spur);
    int idx, tag, p, kind;
    logic [DATA_W-1:0] exp;
    idx = int'(a[2:0]);
    tag = int'(a[11:3]);
    p   = int'(mpred[idx]);
    if (mval[p][idx] && mtag[p][idx] == tag) kind = 0;
    else if (mval[1-p][idx] && mtag[1-p][idx] == tag) kind = 1;
    else kind = 2;
    exp = mem_word(a);

    @(negedge clk);
    chk(req_ready == 1'b1, "R6", "ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = a;
    rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;

    if (kind == 0) begin
      chk(rsp_valid == 1'b1, "R2", "fast rsp_valid c1", rsp_valid, 1);
    end else if (kind == 1) begin
      chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R6", "slow c1 idle outputs", {rsp_valid, req_ready}, 0);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R3", "slow c2 no rsp", {rsp_valid, req_ready}, 0);
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R3", "slow rsp_valid c3", rsp_valid, 1);
    end else begin
      chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R4", "miss c1 quiet", {rsp_valid, mem_req_valid}, 0);
      @(negedge clk);
      chk(mem_req_valid == 1'b1, "R4", "mem_req_valid c2", mem_req_valid, 1);
      chk(mem_req_addr == a, "R4", "mem_req_addr", mem_req_addr, a);
      for (int j = 0; j < mdly; j++) begin
        if (spur && j == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(mem_req_valid == 1'b1 && mem_req_addr == a, "R4", "mem req held", mem_req_addr, a);
        chk(rsp_valid == 1'b0, "R8", "no rsp before refill", rsp_valid, 0);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid == 1'b0, "R4", "mem req dropped", mem_req_valid, 0);
      repeat (2) begin
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R6", "refill wait busy", {rsp_valid, req_ready}, 0);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = exp;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R5", "refill rsp_valid", rsp_valid, 1);
    end
    chk(rsp_data == exp, (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R5", "rsp_data", rsp_data, exp);

    if (hold > 0) begin
      for (int j = 0; j < hold; j++) begin
        @(negedge clk);
        chk(rsp_valid == 1'b1 && rsp_data == exp, "R7", "held rsp", rsp_data, exp);
        chk(req_ready == 1'b0, "R7", "ready low while held", req_ready, 0);
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "rsp cleared after take", rsp_valid, 0);

    if (kind == 0) m_fast++;
    else if (kind == 1) begin m_slow++; mpred[idx] = bit'(1 - p); end
    else begin
      mval[1-p][idx] = 1'b1;
      mtag[1-p][idx] = tag;
      mpred[idx] = bit'(1 - p);
      m_miss++;
    end
    chk_counters((kind == 0) ? "R2" : (kind == 1) ? "R3" : "R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin mval[w][s] = 0; mtag[w][s] = 0; end
    for (int s = 0; s < SETS; s++) mpred[s] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
    chk_counters("R1");

    read_op(12'h010, 0, 0, 0); // cold miss into way 1
    read_op(12'h010, 0, 0, 0); // predicted hit
    read_op(12'h020, 1, 0, 0); // same set miss, fills way 0
    read_op(12'h010, 0, 0, 0); // R9: earlier line survives, other-way hit
    read_op(12'h010, 0, 0, 0); // R3: predictor flipped, now fast
    read_op(12'h020, 0, 0, 0); // other-way hit again
    read_op(12'h033, 3, 0, 1); // R8: stray pulse during stalled refill request
    read_op(12'h033, 0, 3, 0); // R7: held fast response
    read_op(12'h010, 0, 2, 0); // R7: held slow response

    for (int i = 0; i < 40; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'((((i * 7) % 5 + 1) << 3) | ((i * 3) % 4));
      read_op(a, i % 3, (i % 4 == 1) ? 2 : 0, (i % 5 == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule